// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block is a synthesizable behavioural model of a 32-bit synchronous burst RAM with a flow-through read path. All control inputs are sampled on the rising clock edge. An access opens with one of two address strobes, one for the processor and one for the cache controller. A two-bit burst sequencer then walks the low address bits in either linear or interleaved order while the advance input is low. Writes cover the whole word through a global write input, or individual byte lanes through a byte-write enable together with four active-low lane selects.

The shared data bus is split into `wdata`, `rdata` and a drive enable `dq_oe`. Read data for the address taken at a clock edge appears during the cycle that follows that edge. The output enable is asynchronous. The drivers switch off whenever the current cycle is a write, is deselected, or falls in low-power sleep. A sleep request passes through a two-stage synchronizer before the RAM enters sleep. After the request is released, a recovery window of `WAKE_CYC` cycles ignores all strobes, and `wake_busy` is high for that window.

The controller holds five states. `ST_IDLE` means deselected. `ST_READ` and `ST_WRITE` mark an open burst and give the type of the current cycle. `ST_SLEEP` is low power. `ST_WAKE` is the recovery window. The transitions are as follows. A start moves from IDLE, READ or WRITE to READ or WRITE. A deselect leads to IDLE. A continue moves between READ and WRITE according to the write inputs. A synchronized sleep request leads from any active state to SLEEP. Release moves SLEEP to WAKE. When the recovery count expires, WAKE returns to IDLE.

Top module: `fts_burst_ram`

## Requirements
- R1: A cycle started by the processor strobe (`ads_proc_n`=0 with all chip enables active) is always a read. No byte is written on that edge, whatever `gw_n`, `bwe_n` and `bsel_n` are.
- R2: A cycle started by the controller strobe (`ads_ctrl_n`=0, `ads_proc_n`=1, all enables active) writes on that same edge when the write inputs request a write. If any chip enable is inactive, the controller strobe deselects and nothing is written.
- R3: With `gw_n`=0, all four lanes are written, regardless of `bwe_n` and `bsel_n`.
- R4: With `gw_n`=1 and `bwe_n`=0, each low bit `bsel_n[i]` writes lane i, which is bits 8i+7:8i. With all selects high, or with `bwe_n`=1, the cycle is a read.
- R5: When `oe_n` is low, `rdata` carries the word at the address registered on the previous edge, and `dq_oe` is 1 during that same cycle.
- R6: `oe_n` is asynchronous. While it is high, `dq_oe` is 0 with no clock edge needed.
- R7: During any write cycle, including a partial byte write, `dq_oe` is 0 even when `oe_n` is low.
- R8: The RAM deselects when a controller strobe arrives with an inactive enable, or a processor strobe arrives with `ce1_n`=0 and another enable inactive. A deselected RAM leaves `dq_oe` at 0. A processor strobe with `ce1_n`=1 and `ads_ctrl_n`=1 is ignored, and the open burst continues.
- R9: Burst offset k from a start low-address s is s+k mod 4 when `burst_ilv`=0, and s XOR k when `burst_ilv`=1. The offset advances on each continue edge with `adv_n`=0 and holds when `adv_n`=1.
- R10: A continue edge in an open burst writes the advanced address when the write inputs request a write.
- R11: Once `sleep_req` has been high at two edges, the next edge enters sleep. In sleep, `dq_oe` is 0, all other inputs are ignored, and the array contents are kept.
- R12: After `sleep_req` falls and has passed the synchronizer, `wake_busy` is high for exactly `WAKE_CYC` (default 2) cycles. Strobes during that window start no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep_req | input | 1 | Sleep request, asynchronous, active high |
| wdata | input | 32 | Write data half of the shared bus |
| rdata | output | 32 | Read data half of the shared bus |
| dq_oe | output | 1 | Bus drive enable |
| wake_busy | output | 1 | Sleep recovery in progress |

## Verification
The bench uses the defaults `AW`=6 and `WAKE_CYC`=2. A 64-word array lets full four-beat bursts in both orders run on aligned and unaligned starts, and writes to each lane pattern land in distinct words. It also keeps the reference model small. With a two-cycle recovery window, the bench can count the exact duration of `wake_busy`. It can also place a write strobe inside that window and then confirm through a later read that the strobe was dropped.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int LANES = 4;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } ram_state_e;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          ilv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_cur,
    output logic [AW-1:0] addr_nxt
);
    logic [AW-3:0] base_q;
    logic [1:0]    start_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_inc;

    function automatic logic [1:0] order(input logic [1:0] s, input logic [1:0] k,
                                         input logic il);
        return il ? (s ^ k) : (s + k);
    endfunction

    assign cnt_inc  = cnt_q + 2'd1;
    assign addr_cur = {base_q, order(start_q, cnt_q, ilv)};

    always_comb begin
        if (load)
            addr_nxt = addr_in;
        else if (advance)
            addr_nxt = {base_q, order(start_q, cnt_inc, ilv)};
        else
            addr_nxt = addr_cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            base_q  <= addr_in[AW-1:2];
            start_q <= addr_in[1:0];
            cnt_q   <= '0;
        end else if (advance) begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/fts_lane_mem.sv
module fts_lane_mem
    import fts_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [AW-1:0]           waddr,
    input  logic [AW-1:0]           raddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g])
                arr[waddr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = arr[raddr];
    end
endmodule

// File: rtl/fts_sleep_ctl.sv
module fts_sleep_ctl #(
    parameter int WAKE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_start,
    input  logic in_wake,
    output logic sleep_s,
    output logic wake_zero
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    logic          sync1_q;
    logic          sync2_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= sleep_req;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wake_start)
            cnt_q <= CW'(WAKE_CYC - 1);
        else if (in_wake && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign sleep_s   = sync2_q;
    assign wake_zero = (cnt_q == '0);
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
    import fts_pkg::*;
#(
    parameter int AW       = 6,
    parameter int WAKE_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    ads_proc_n,
    input  logic                    ads_ctrl_n,
    input  logic                    adv_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bsel_n,
    input  logic                    oe_n,
    input  logic                    burst_ilv,
    input  logic                    sleep_req,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    dq_oe,
    output logic                    wake_busy
);
    ram_state_e       state_q, state_d;
    logic             sleep_s, wake_zero, wake_start;
    logic             load, advance;
    logic [LANES-1:0] lane_we, wr_mask;
    logic [AW-1:0]    addr_cur, addr_nxt;
    logic             ce_all, wr_req, start_p, start_c, desel;

    // Input qualification
    assign ce_all  = !ce1_n && ce2 && !ce3_n;
    assign wr_mask = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bsel_n : '0);
    assign wr_req  = |wr_mask;
    assign start_p = ce_all && !ads_proc_n;
    assign start_c = ce_all && ads_proc_n && !ads_ctrl_n;
    assign desel   = !start_p && !start_c &&
                     (!ads_ctrl_n || (!ads_proc_n && !ce1_n));

    // Next-state and datapath control
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        advance = 1'b0;
        lane_we = '0;
        unique case (state_q)
            ST_SLEEP: begin
                if (!sleep_s)
                    state_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (sleep_s)
                    state_d = ST_SLEEP;
                else if (wake_zero)
                    state_d = ST_IDLE;
            end
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (sleep_s) begin
                    state_d = ST_SLEEP;
                end else if (start_p) begin
                    load    = 1'b1;
                    state_d = ST_READ;
                end else if (start_c) begin
                    load    = 1'b1;
                    lane_we = wr_mask;
                    state_d = wr_req ? ST_WRITE : ST_READ;
                end else if (desel) begin
                    state_d = ST_IDLE;
                end else if (state_q != ST_IDLE) begin
                    advance = !adv_n;
                    lane_we = wr_mask;
                    state_d = wr_req ? ST_WRITE : ST_READ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        dq_oe     = (state_q == ST_READ) && !oe_n;
        wake_busy = (state_q == ST_WAKE);
    end

    assign wake_start = (state_q == ST_SLEEP) && (state_d == ST_WAKE);

    fts_sleep_ctl #(.WAKE_CYC(WAKE_CYC)) sleep_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_start (wake_start),
        .in_wake    (state_q == ST_WAKE),
        .sleep_s    (sleep_s),
        .wake_zero  (wake_zero)
    );

    fts_burst_seq #(.AW(AW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .ilv      (burst_ilv),
        .addr_in  (addr),
        .addr_cur (addr_cur),
        .addr_nxt (addr_nxt)
    );

    fts_lane_mem #(.AW(AW)) mem_i (
        .clk   (clk),
        .we    (lane_we),
        .waddr (addr_nxt),
        .raddr (addr_cur),
        .wdata (wdata),
        .rdata (rdata)
    );
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk
    import fts_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input ram_state_e       state_q,
    input logic             sleep_s,
    input logic             ce1_n,
    input logic             ce2,
    input logic             ce3_n,
    input logic             ads_proc_n,
    input logic             gw_n,
    input logic             oe_n,
    input logic [LANES-1:0] lane_we,
    input logic             dq_oe,
    input logic             wake_busy
);
    logic awake;
    assign awake = !sleep_s && (state_q == ST_IDLE || state_q == ST_READ ||
                                state_q == ST_WRITE);

    // R1: processor-strobe start writes nothing and opens a read
    a_r1_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !ce1_n && ce2 && !ce3_n && !ads_proc_n) |-> lane_we == '0);
    a_r1_proc_state: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !ce1_n && ce2 && !ce3_n && !ads_proc_n) |=> state_q == ST_READ);
    // R3: a global write touches every lane
    a_r3_gw_all: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0 && !gw_n) |-> lane_we == {LANES{1'b1}});
    // R6: output enable high keeps the bus undriven
    a_r6_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);
    // R7: no drive during a write cycle
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WRITE |-> !dq_oe);
    // R11: sleep writes nothing and drives nothing
    a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SLEEP |-> (!dq_oe && lane_we == '0));
    // R12: recovery window writes nothing and lasts beyond one cycle
    a_r12_wake_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        wake_busy |-> lane_we == '0);
    a_r12_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wake_busy) && !sleep_s) |=> wake_busy);
endmodule

bind fts_burst_ram fts_burst_ram_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .sleep_s    (sleep_s),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .ads_proc_n (ads_proc_n),
    .gw_n       (gw_n),
    .oe_n       (oe_n),
    .lane_we    (lane_we),
    .dq_oe      (dq_oe),
    .wake_busy  (wake_busy)
);

// File: tb/fts_burst_ram_tb_top.sv
module fts_burst_ram_tb_top;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bsel_n = 4'hF;
    logic          oe_n = 1'b0, burst_ilv = 1'b0, sleep_req = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          dq_oe, wake_busy;

    logic [31:0] model [DEPTH];
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fts_burst_ram #(.AW(AW), .WAKE_CYC(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ads_proc_n(ads_proc_n),
        .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
        .burst_ilv(burst_ilv), .sleep_req(sleep_req), .wdata(wdata),
        .rdata(rdata), .dq_oe(dq_oe), .wake_busy(wake_busy)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
        ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0;
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++)
            if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic ctrl_cycle(input logic [AW-1:0] a, input logic [31:0] d,
                              input logic g, input logic be, input logic [3:0] bs);
        logic [3:0] m;
        m = !g ? 4'hF : (!be ? ~bs : 4'h0);
        quiet();
        ce1_n = 1'b0; ads_ctrl_n = 1'b0; addr = a; wdata = d;
        gw_n = g; bwe_n = be; bsel_n = bs;
        step();
        model[a] = merge(model[a], d, m);
        quiet();
    endtask

    task automatic proc_read(input string rq, input logic [AW-1:0] a);
        quiet();
        ce1_n = 1'b0; ads_proc_n = 1'b0; addr = a;
        step();
        quiet();
        check({rq, " drive"}, {31'd0, dq_oe}, 32'd1);
        check({rq, " data"}, rdata, model[a]);
    endtask

    task automatic t_reset();
        check("R5 reset dq_oe", {31'd0, dq_oe}, 32'd0);
        check("R12 reset wake_busy", {31'd0, wake_busy}, 32'd0);
    endtask

    task automatic t_ctrl_write();
        ctrl_cycle(6'd3, 32'hA5A5_1234, 1'b0, 1'b1, 4'hF);
        check("R7 write no drive", {31'd0, dq_oe}, 32'd0);
        proc_read("R2/R5 ctrl write readback", 6'd3);
    endtask

    task automatic t_global();
        ctrl_cycle(6'd4, 32'h1111_1111, 1'b0, 1'b1, 4'hF);
        ctrl_cycle(6'd4, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'hE);
        proc_read("R3 global write all lanes", 6'd4);
    endtask

    task automatic t_bytes();
        ctrl_cycle(6'd5, 32'h0000_0000, 1'b0, 1'b1, 4'hF);
        ctrl_cycle(6'd5, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010);
        check("R7 byte write no drive", {31'd0, dq_oe}, 32'd0);
        proc_read("R4 lanes 0 and 2", 6'd5);
        ctrl_cycle(6'd5, 32'h1122_3344, 1'b1, 1'b0, 4'b0111);
        proc_read("R4 lane 3", 6'd5);
        ctrl_cycle(6'd5, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'hF);
        check("R4 all selects high reads", {31'd0, dq_oe}, 32'd1);
        ctrl_cycle(6'd5, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0);
        proc_read("R4 bwe high is read", 6'd5);
    endtask

    task automatic t_proc_ignores_write();
        ctrl_cycle(6'd6, 32'h0606_0606, 1'b0, 1'b1, 4'hF);
        quiet();
        ce1_n = 1'b0; ads_proc_n = 1'b0; addr = 6'd6;
        gw_n = 1'b0; wdata = 32'hBAD0_BAD0;
        step();
        quiet();
        check("R1 proc start drives", {31'd0, dq_oe}, 32'd1);
        check("R1 proc start old data", rdata, model[6]);
        proc_read("R1 no write happened", 6'd6);
    endtask

    task automatic t_burst();
        logic [AW-1:0] a;
        burst_ilv = 1'b0;
        ctrl_cycle(6'd9, 32'hC000_0000, 1'b0, 1'b1, 4'hF);
        for (int k = 1; k < 4; k++) begin
            quiet(); adv_n = 1'b0; gw_n = 1'b0; wdata = 32'hC000_0000 + k;
            step();
            a = {4'd2, 2'(2'd1 + 2'(k))};
            model[a] = 32'hC000_0000 + k;
            check("R10 continue write no drive", {31'd0, dq_oe}, 32'd0);
        end
        quiet();
        proc_read("R9 linear beat0", 6'd9);
        for (int k = 1; k < 4; k++) begin
            quiet(); adv_n = 1'b0;
            step();
            a = {4'd2, 2'(2'd1 + 2'(k))};
            check("R9/R10 linear beat", rdata, model[a]);
        end
        quiet();
        burst_ilv = 1'b1;
        proc_read("R9 interleaved beat0", 6'd9);
        quiet(); adv_n = 1'b0;
        step();
        check("R9 interleaved beat1", rdata, model[8]);
        quiet();
        step();
        check("R9 suspend holds", rdata, model[8]);
        adv_n = 1'b0;
        step();
        check("R9 interleaved beat2", rdata, model[11]);
        step();
        check("R9 interleaved beat3", rdata, model[10]);
        quiet();
        burst_ilv = 1'b0;
    endtask

    task automatic t_oe();
        proc_read("R5 pre oe", 6'd3);
        #3 oe_n = 1'b1;
        #1 check("R6 async oe off", {31'd0, dq_oe}, 32'd0);
        #1 oe_n = 1'b0;
        #1 check("R6 async oe on", {31'd0, dq_oe}, 32'd1);
    endtask

    task automatic t_deselect();
        proc_read("R8 open burst", 6'd3);
        quiet(); ce1_n = 1'b1; ads_proc_n = 1'b0; addr = 6'd20;
        step();
        quiet();
        check("R8 masked proc strobe keeps drive", {31'd0, dq_oe}, 32'd1);
        check("R8 masked proc strobe keeps data", rdata, model[3]);
        quiet(); ce1_n = 1'b0; ce2 = 1'b0; ads_ctrl_n = 1'b0;
        addr = 6'd3; gw_n = 1'b0; wdata = 32'h0BAD_0BAD;
        step();
        quiet();
        check("R8 deselect no drive", {31'd0, dq_oe}, 32'd0);
        proc_read("R2 deselected write ignored", 6'd3);
    endtask

    task automatic t_sleep();
        int busy;
        ctrl_cycle(6'd20, 32'h5EE9_0020, 1'b0, 1'b1, 4'hF);
        proc_read("R11 pre sleep", 6'd20);
        sleep_req = 1'b1;
        step(); step(); step();
        check("R11 sleep no drive", {31'd0, dq_oe}, 32'd0);
        ce1_n = 1'b0; ads_ctrl_n = 1'b0; addr = 6'd20; gw_n = 1'b0;
        wdata = 32'h0000_BAD1;
        step(); step();
        quiet();
        sleep_req = 1'b0;
        busy = 0;
        for (int i = 0; i < 8 && busy == 0; i++) begin
            step();
            if (wake_busy) busy = 1;
        end
        ce1_n = 1'b0; ads_ctrl_n = 1'b0; addr = 6'd20; gw_n = 1'b0;
        wdata = 32'h0000_BAD2;
        step();
        quiet();
        for (int i = 0; i < 8 && wake_busy; i++) begin
            busy++;
            step();
        end
        check("R12 recovery length", busy, 2);
        proc_read("R11/R12 contents kept", 6'd20);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ctrl_write();
        t_global();
        t_bytes();
        t_proc_ignores_write();
        t_burst();
        t_oe();
        t_deselect();
        t_sleep();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule